// File: doc/BRIEF.md
# Two-Wire Serial-Bus Byte Master

This block is a master for a two-wire serial bus. It carries out one register-addressed single-byte write or one single-byte read to a slave, each started by software. The host presents a 7-bit slave address, an 8-bit register (word) address, a write data byte and a read/write select, then pulses a go strobe. The block captures these values, runs the whole bus sequence by itself, and then reports the outcome through a one-clock done pulse, a read-data byte and a sticky no-acknowledge flag.

Both bus lines are open-drain. For each line the block provides an output-enable: when the enable is high, the line is pulled low; when it is low, the line is released. The bit clock is built from quarter phases. Each quarter lasts a programmable number of system clocks, so a system clock of a few tens of MHz gives a bus clock close to 100 kHz. When no transfer is running, both lines stay released and nothing toggles.

A write sends the slave address with direction bit 0, the word address and the data byte. A read sends the slave address with direction bit 0 and the word address, then a repeated start, the slave address with direction bit 1, eight bits from the slave and a master no-acknowledge. If any slave acknowledge is missing, the block sets the flag, sends a stop and returns to idle.

Top module: `serial_byte_master`

## Requirements
- R1: After reset, and at any time no transfer is running, busy, done, nackFlag, sclOe and sdaOe are all 0. Both lines therefore stay released and do not toggle.
- R2: Every bit slot is made of four quarters. Each quarter lasts quarterDiv system clocks, and a value of 0 counts as 1. Quarter 0 of the first slot begins at the clock edge that samples goReq high while the block is idle.
- R3: The first slot is a start. SCL stays released for all four quarters, and sdaOe rises at the beginning of quarter 2.
- R4: In every data or acknowledge slot, SCL is pulled low in quarters 0 and 1 and released in quarters 2 and 3. sdaOe changes only at the beginning of quarter 1. Transmitted bits go most significant bit first, and sdaOe = 1 sends a 0 bit.
- R5: A write (rdNotWr = 0) sends these slots in order: start, {slaveAddr, 0}, ack, wordAddr, ack, wrData, ack, stop. In each ack slot sdaOe is 0. In the stop slot, SCL is low in quarters 0 and 1 and released from quarter 2, while sdaOe is 1 from quarter 1 until it falls at the beginning of quarter 3.
- R6: A read (rdNotWr = 1) sends start, {slaveAddr, 0}, ack, wordAddr, ack, then a repeated start, then {slaveAddr, 1}, ack, eight slave bits, a master no-acknowledge slot with sdaOe 0, and stop. The repeated start has SCL low in quarters 0 and 1, sdaOe falls at quarter 1, SCL is released at quarter 2 and sdaOe rises at quarter 3. Each slave bit is sampled at the beginning of quarter 3. rdData takes the received byte only when a read completes with every acknowledge present.
- R7: Each acknowledge is sampled from sdaIn at the beginning of quarter 3 of its slot, where low means acknowledged. A missing acknowledge sets nackFlag, and the next slot is a stop.
- R8: nackFlag stays set until a clock edge with clrNack high and no new missing acknowledge clears it.
- R9: A goReq while busy is ignored. Changing slaveAddr, wordAddr, wrData or rdNotWr after acceptance has no effect on the running transfer.
- R10: At the edge that ends quarter 3 of the stop slot, busy falls and done is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| quarterDiv | input | DIV_W | System clocks per quarter of a bit slot |
| goReq | input | 1 | Start a transfer when idle |
| rdNotWr | input | 1 | 1 = read, 0 = write |
| slaveAddr | input | 7 | Slave device address |
| wordAddr | input | 8 | Register address inside the slave |
| wrData | input | 8 | Byte to write |
| clrNack | input | 1 | Clear the no-acknowledge flag |
| sdaIn | input | 1 | Sensed level of the data line |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse at the end of a transfer |
| rdData | output | 8 | Last byte read successfully |
| nackFlag | output | 1 | Sticky missing-acknowledge flag |
| sclOe | output | 1 | Pull clock line low when 1 |
| sdaOe | output | 1 | Pull data line low when 1 |

## Verification
The bench builds the block with the default DIV_W of 16 and drives quarterDiv at 1, 2 and 3. At these values every quarter boundary of a full 39-slot read lies within a few hundred cycles, so the model can compare the line levels on every clock. The value 1 also exercises the case where the divider ticks on back-to-back clocks. A slave model that can withhold the acknowledge at any of the three checked bytes reaches every early-stop path. A go pulse during a transfer, together with altered inputs, shows that the captured request is the one that completes.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int ADDR_BITS = 7;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [3:0] {
    SEG_IDLE, SEG_START, SEG_ADDR, SEG_WADDR, SEG_WDATA,
    SEG_RSTART, SEG_RADDR, SEG_RDATA, SEG_STOP
  } segE;

  typedef enum logic [1:0] {SDA_KEEP, SDA_PULL, SDA_FREE, SDA_BIT} sdaOpE;

  typedef enum logic [1:0] {BYTE_ADDR_WR, BYTE_ADDR_RD, BYTE_WORD, BYTE_DATA} byteSelE;

  typedef struct packed {
    logic    run;
    logic    capture;
    logic    loadByte;
    byteSelE byteSel;
    logic    shiftIn;
    logic    ackSample;
    logic    sclSet;
    logic    sclLow;
    sdaOpE   sdaOp;
    logic    rdLatch;
  } ctrlStrobeT;
endpackage

// File: rtl/sbm_qdiv.sv
module sbm_qdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cntInc;

  assign cntInc = {1'b0, cnt} + 1'b1;
  assign tick   = run && (cntInc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && limit > 1) |=> (!tick || limit <= 1));
endmodule

// File: rtl/sbm_datapath.sv
module sbm_datapath import sbm_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobeT           st,
  input  logic [DIV_W-1:0]     quarterDiv,
  input  logic [ADDR_BITS-1:0] slaveAddr,
  input  logic [BYTE_BITS-1:0] wordAddr,
  input  logic [BYTE_BITS-1:0] wrData,
  input  logic                 rdNotWr,
  input  logic                 clrNack,
  input  logic                 sdaIn,
  output logic                 tick,
  output logic                 rdMode,
  output logic                 lastSample,
  output logic                 sclOe,
  output logic                 sdaOe,
  output logic [BYTE_BITS-1:0] rdData,
  output logic                 nackFlag
);
  logic [ADDR_BITS-1:0] addrR;
  logic [BYTE_BITS-1:0] wordR, dataR, shiftR;

  sbm_qdiv #(.DIV_W(DIV_W)) i_qdiv (
    .clk(clk), .rstN(rstN), .run(st.run), .limit(quarterDiv), .tick(tick)
  );

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      wordR  <= '0;
      dataR  <= '0;
      rdMode <= 1'b0;
    end else if (st.capture) begin
      addrR  <= slaveAddr;
      wordR  <= wordAddr;
      dataR  <= wrData;
      rdMode <= rdNotWr;
    end
  end

  // byte shifter, shared by transmit and receive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftR     <= '0;
      lastSample <= 1'b0;
    end else begin
      if (st.loadByte) begin
        unique case (st.byteSel)
          BYTE_ADDR_WR: shiftR <= {addrR, 1'b0};
          BYTE_ADDR_RD: shiftR <= {addrR, 1'b1};
          BYTE_WORD:    shiftR <= wordR;
          default:      shiftR <= dataR;
        endcase
      end else if (st.shiftIn) begin
        shiftR <= {shiftR[BYTE_BITS-2:0], sdaIn};
      end
      if (st.shiftIn || st.ackSample) lastSample <= sdaIn;
    end
  end

  // line drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      if (st.sclSet) sclOe <= st.sclLow;
      unique case (st.sdaOp)
        SDA_PULL: sdaOe <= 1'b1;
        SDA_FREE: sdaOe <= 1'b0;
        SDA_BIT:  sdaOe <= ~shiftR[BYTE_BITS-1];
        default:  ;
      endcase
    end
  end

  // result and status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      nackFlag <= 1'b0;
    end else begin
      if (st.rdLatch) rdData <= shiftR;
      if (clrNack) nackFlag <= 1'b0;
      if (st.ackSample && sdaIn) nackFlag <= 1'b1;
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.run |-> (!sclOe && !sdaOe));

  // R8
  nack_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nackFlag && !clrNack) |=> nackFlag);
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl import sbm_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       goReq,
  input  logic       tick,
  input  logic       rdMode,
  input  logic       lastSample,
  input  logic       sclOe,
  input  logic       sdaOe,
  output ctrlStrobeT st,
  output logic       busy,
  output logic       done
);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(BYTE_BITS);

  segE              seg, nSeg;
  logic [1:0]       qIdx, nQ;
  logic [CNT_W-1:0] bitCnt, nBit;
  logic             enter, doneNext;

  function automatic logic isByte(segE s);
    return (s == SEG_ADDR) || (s == SEG_WADDR) || (s == SEG_WDATA) ||
           (s == SEG_RADDR) || (s == SEG_RDATA);
  endfunction

  assign busy = (seg != SEG_IDLE);

  always_comb begin
    st       = '0;
    nSeg     = seg;
    nQ       = qIdx;
    nBit     = bitCnt;
    enter    = 1'b0;
    doneNext = 1'b0;
    st.run   = busy;
    // sequencing: which quarter is entered next
    if (seg == SEG_IDLE) begin
      if (goReq) begin
        st.capture = 1'b1;
        nSeg       = SEG_START;
        nQ         = 2'd0;
        nBit       = '0;
      end
    end else if (tick) begin
      enter = 1'b1;
      if (qIdx != 2'd3) begin
        nQ = qIdx + 2'd1;
      end else begin
        nQ = 2'd0;
        unique case (seg)
          SEG_START: begin
            nSeg        = SEG_ADDR;
            nBit        = '0;
            st.loadByte = 1'b1;
            st.byteSel  = BYTE_ADDR_WR;
          end
          SEG_RSTART: begin
            nSeg        = SEG_RADDR;
            nBit        = '0;
            st.loadByte = 1'b1;
            st.byteSel  = BYTE_ADDR_RD;
          end
          SEG_STOP: begin
            nSeg     = SEG_IDLE;
            enter    = 1'b0;
            doneNext = 1'b1;
          end
          default: begin
            if (bitCnt != ACK_IDX) begin
              nBit = bitCnt + CNT_W'(1);
            end else begin
              nBit = '0;
              if (seg != SEG_RDATA && lastSample) begin
                nSeg = SEG_STOP;
              end else begin
                unique case (seg)
                  SEG_ADDR: begin
                    nSeg        = SEG_WADDR;
                    st.loadByte = 1'b1;
                    st.byteSel  = BYTE_WORD;
                  end
                  SEG_WADDR: begin
                    if (rdMode) begin
                      nSeg = SEG_RSTART;
                    end else begin
                      nSeg        = SEG_WDATA;
                      st.loadByte = 1'b1;
                      st.byteSel  = BYTE_DATA;
                    end
                  end
                  SEG_RADDR: nSeg = SEG_RDATA;
                  SEG_RDATA: begin
                    nSeg       = SEG_STOP;
                    st.rdLatch = 1'b1;
                  end
                  default:   nSeg = SEG_STOP;
                endcase
              end
            end
          end
        endcase
      end
    end
    // line actions for the quarter being entered
    if (enter) begin
      if (nSeg != SEG_START) begin
        if (nQ == 2'd0) begin
          st.sclSet = 1'b1;
          st.sclLow = 1'b1;
        end else if (nQ == 2'd2) begin
          st.sclSet = 1'b1;
          st.sclLow = 1'b0;
        end
      end
      unique case (nSeg)
        SEG_START: begin
          if (nQ == 2'd2) st.sdaOp = SDA_PULL;
        end
        SEG_RSTART: begin
          if (nQ == 2'd1)      st.sdaOp = SDA_FREE;
          else if (nQ == 2'd3) st.sdaOp = SDA_PULL;
        end
        SEG_STOP: begin
          if (nQ == 2'd1)      st.sdaOp = SDA_PULL;
          else if (nQ == 2'd3) st.sdaOp = SDA_FREE;
        end
        default: begin
          if (nQ == 2'd1) begin
            st.sdaOp = (nBit == ACK_IDX || nSeg == SEG_RDATA) ? SDA_FREE : SDA_BIT;
          end else if (nQ == 2'd3) begin
            if (nBit != ACK_IDX)         st.shiftIn   = 1'b1;
            else if (nSeg != SEG_RDATA)  st.ackSample = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg    <= SEG_IDLE;
      qIdx   <= 2'd0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      seg    <= nSeg;
      qIdx   <= nQ;
      bitCnt <= nBit;
      done   <= doneNext;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R4
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isByte(seg) && isByte($past(seg)) && !sclOe && !$past(sclOe)) |-> $stable(sdaOe));

  // R7
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && qIdx == 2'd3 && bitCnt == ACK_IDX && isByte(seg) &&
     seg != SEG_RDATA && lastSample) |=> (seg == SEG_STOP));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && seg != SEG_STOP) |=> busy);
endmodule

// File: rtl/serial_byte_master.sv
module serial_byte_master import sbm_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_W-1:0]     quarterDiv,
  input  logic                 goReq,
  input  logic                 rdNotWr,
  input  logic [ADDR_BITS-1:0] slaveAddr,
  input  logic [BYTE_BITS-1:0] wordAddr,
  input  logic [BYTE_BITS-1:0] wrData,
  input  logic                 clrNack,
  input  logic                 sdaIn,
  output logic                 busy,
  output logic                 done,
  output logic [BYTE_BITS-1:0] rdData,
  output logic                 nackFlag,
  output logic                 sclOe,
  output logic                 sdaOe
);
  ctrlStrobeT st;
  logic tick, rdMode, lastSample;

  sbm_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .goReq(goReq), .tick(tick), .rdMode(rdMode),
    .lastSample(lastSample), .sclOe(sclOe), .sdaOe(sdaOe),
    .st(st), .busy(busy), .done(done)
  );

  sbm_datapath #(.DIV_W(DIV_W)) i_datapath (
    .clk(clk), .rstN(rstN), .st(st), .quarterDiv(quarterDiv),
    .slaveAddr(slaveAddr), .wordAddr(wordAddr), .wrData(wrData),
    .rdNotWr(rdNotWr), .clrNack(clrNack), .sdaIn(sdaIn),
    .tick(tick), .rdMode(rdMode), .lastSample(lastSample),
    .sclOe(sclOe), .sdaOe(sdaOe), .rdData(rdData), .nackFlag(nackFlag)
  );
endmodule

// File: tb/test_serial_byte_master.sv
module test_serial_byte_master;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [DIV_W-1:0] quarterDiv = 16'd2;
  logic goReq = 1'b0, rdNotWr = 1'b0, clrNack = 1'b0, slvLow = 1'b0;
  logic [6:0] slaveAddr = '0;
  logic [7:0] wordAddr = '0, wrData = '0;
  logic busy, done, nackFlag, sclOe, sdaOe, sdaIn;
  logic [7:0] rdData;

  assign sdaIn = !(slvLow || sdaOe);

  serial_byte_master #(.DIV_W(DIV_W)) i_serial_byte_master (
    .clk(clk), .rstN(rstN), .quarterDiv(quarterDiv), .goReq(goReq),
    .rdNotWr(rdNotWr), .slaveAddr(slaveAddr), .wordAddr(wordAddr),
    .wrData(wrData), .clrNack(clrNack), .sdaIn(sdaIn), .busy(busy),
    .done(done), .rdData(rdData), .nackFlag(nackFlag), .sclOe(sclOe),
    .sdaOe(sdaOe)
  );

  int nChecks = 0, nErr = 0;
  bit finished = 0;
  bit qScl[$], qSda[$], qSlv[$];
  bit prevSda;
  bit expNack = 0;
  logic [7:0] expRd = '0;

  task automatic check(string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // quarter-level reference waveform: clock pull, data pull, slave pull
  task automatic addQ(bit s, bit d, bit l);
    qScl.push_back(s); qSda.push_back(d); qSlv.push_back(l);
  endtask
  task automatic addStart();
    addQ(0, 0, 0); addQ(0, 0, 0); addQ(0, 1, 0); addQ(0, 1, 0);
    prevSda = 1;
  endtask
  task automatic addRestart();
    addQ(1, prevSda, 0); addQ(1, 0, 0); addQ(0, 0, 0); addQ(0, 1, 0);
    prevSda = 1;
  endtask
  task automatic addBit(bit drv, bit slv);
    addQ(1, prevSda, slv); addQ(1, drv, slv); addQ(0, drv, slv); addQ(0, drv, slv);
    prevSda = drv;
  endtask
  task automatic addStop();
    addQ(1, prevSda, 0); addQ(1, 1, 0); addQ(0, 1, 0); addQ(0, 0, 0);
    prevSda = 0;
  endtask
  task automatic addTxByte(logic [7:0] b, bit ack);
    for (int i = 7; i >= 0; i--) addBit(!b[i], 0);
    addBit(0, ack);
  endtask
  task automatic addRxByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) addBit(0, !b[i]);
    addBit(0, 0);
  endtask

  task automatic idleCheck(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R1 idle sclOe", sclOe, 0);
      check("R1 idle sdaOe", sdaOe, 0);
      check("R1 idle busy", busy, 0);
      check("R8 nackFlag held while idle", nackFlag, expNack);
    end
  endtask

  task automatic runTxn(string tag, bit rd, logic [6:0] addr, logic [7:0] word,
                        logic [7:0] data, logic [7:0] rx, bit [2:0] acks,
                        int d, bit poke);
    bit miss;
    int total;
    qScl.delete(); qSda.delete(); qSlv.delete();
    prevSda = 0;
    miss = 0;
    addStart();
    addTxByte({addr, 1'b0}, acks[0]);
    if (!acks[0]) miss = 1;
    else begin
      addTxByte(word, acks[1]);
      if (!acks[1]) miss = 1;
      else if (!rd) begin
        addTxByte(data, acks[2]);
        if (!acks[2]) miss = 1;
      end else begin
        addRestart();
        addTxByte({addr, 1'b1}, acks[2]);
        if (!acks[2]) miss = 1;
        else addRxByte(rx);
      end
    end
    addStop();
    if (miss) expNack = 1;
    if (rd && !miss) expRd = rx;

    @(negedge clk);
    quarterDiv = DIV_W'(d);
    rdNotWr = rd; slaveAddr = addr; wordAddr = word; wrData = data;
    goReq = 1;
    @(negedge clk);
    goReq = 0;
    slaveAddr = ~addr; wordAddr = ~word; wrData = ~data; rdNotWr = !rd;
    total = qScl.size() * d;
    for (int t = 0; t < total; t++) begin
      if (t > 0) @(negedge clk);
      slvLow = qSlv[t / d];
      goReq = (poke && (t == 7 || t == 40)) ? 1'b1 : 1'b0;
      check({"R2 R4 sclOe ", tag}, sclOe, qScl[t / d]);
      check({"R3 sdaOe ", tag}, sdaOe, qSda[t / d]);
      check({"R10 busy ", tag}, busy, 1);
      check({"R10 done early ", tag}, done, 0);
    end
    @(negedge clk);
    slvLow = 0;
    goReq = 0;
    check({"R10 busy end ", tag}, busy, 0);
    check({"R10 done end ", tag}, done, 1);
    check({"R1 sclOe end ", tag}, sclOe, 0);
    check({"R1 sdaOe end ", tag}, sdaOe, 0);
    check({"R6 rdData ", tag}, rdData, expRd);
    check({"R7 nackFlag ", tag}, nackFlag, expNack);
    @(negedge clk);
    check({"R10 done width ", tag}, done, 0);
  endtask

  task automatic clearNack();
    @(negedge clk);
    clrNack = 1;
    @(negedge clk);
    clrNack = 0;
    expNack = 0;
    check("R8 nackFlag cleared", nackFlag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    check("R1 reset nackFlag", nackFlag, 0);
    check("R1 reset sclOe", sclOe, 0);
    check("R1 reset sdaOe", sdaOe, 0);
    rstN = 1;
    idleCheck(20);
    runTxn("R5 write", 0, 7'h50, 8'h12, 8'hC3, 8'h00, 3'b111, 2, 0);
    idleCheck(5);
    runTxn("R6 read", 1, 7'h2A, 8'h80, 8'h00, 8'hA5, 3'b111, 3, 0);
    runTxn("R7 data nack", 0, 7'h11, 8'h07, 8'h5A, 8'h00, 3'b011, 1, 0);
    idleCheck(10);
    clearNack();
    runTxn("R7 addr nack read", 1, 7'h7F, 8'hFF, 8'h00, 8'h99, 3'b110, 2, 0);
    clearNack();
    runTxn("R9 go while busy", 0, 7'h01, 8'hFE, 8'h01, 8'h00, 3'b111, 2, 1);
    runTxn("R6 read fast", 1, 7'h63, 8'h3C, 8'h00, 8'h0F, 3'b111, 1, 0);
    runTxn("R7 read second addr nack", 1, 7'h05, 8'h44, 8'h00, 8'hEE, 3'b011, 2, 0);
    runTxn("R5 write after nack", 0, 7'h40, 8'h00, 8'hFF, 8'h00, 3'b111, 3, 0);
    clearNack();
    idleCheck(5);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      nChecks++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule